// File: doc/BRIEF.md
# PWM Sample Timer with Interrupt Divider

This block sets the sample rate of a two-channel pulse-width audio unit. A 12-bit period register gives the length of one sample period in clock cycles. At the end of every period the block pops one value from each of two small pulse-width queues, a left one and a right one, and presents the popped values as the current pulse widths. If a queue has run dry, its output keeps the last value that was popped.

A 4-bit divider counts sample periods. After every N periods it latches an interrupt that stays set until software writes the acknowledge address. If the refill-request enable bit is set, the same event also drives a one-cycle DMA request so that an external engine can top the queues up.

Writes arrive on a simple port of enable, address and data. Address 0 is control, 1 is the period, 2 feeds the left queue, 3 feeds the right queue, and 4 is the acknowledge.

Top module: `pwm_sample_timer`

## Requirements
- R1: A write to address 1 stores wrData[11:0] as the period P and ignores bits 15:12. While P is not 0, a pop happens every P clock cycles, counted from the write.
- R2: A write to address 2 (left) or 3 (right) enqueues (wrData - 1) mod 4096. The popped value appears on leftPulse or rightPulse after the clock edge that ends the period.
- R3: A write to address 0 sets the divider N from wrData[11:8], and a field value of 0 means 16. irqPending rises on the edge of the N-th pop after the divider was loaded, and again every N pops after that.
- R4: While P is 0, no pops happen and no interrupt is raised, and queued entries stay in place.
- R5: A write to address 0 reloads the divider count to N. Periods counted before the write do not count towards the next interrupt.
- R6: When control bit 7 is 1, each interrupt event drives dmaReq high for exactly the one cycle after the event edge. When bit 7 is 0, dmaReq stays low.
- R7: In leftStatus and rightStatus, bit 15 is 1 when the queue is full, bit 14 is 1 when it is empty, and bits 13:0 read 0.
- R8: irqPending stays 1 until a write to address 4 clears it. An event in the same cycle as the acknowledge wins.
- R9: Each queue holds 3 entries, and a write to a full queue is dropped. A pop from an empty queue leaves the output value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0 control, 1 period, 2 left, 3 right, 4 ack) |
| wrData | input | 16 | Write data |
| leftPulse | output | 12 | Current left pulse width |
| rightPulse | output | 12 | Current right pulse width |
| leftStatus | output | 16 | Left queue status (15 full, 14 empty) |
| rightStatus | output | 16 | Right queue status (15 full, 14 empty) |
| irqPending | output | 1 | Latched interrupt |
| dmaReq | output | 1 | One-cycle DMA refill request |

## Verification
A wrong period count shifts the edge on which leftPulse and rightPulse change, so it shows within one period. A divider count that is off by one, or that is not reloaded by a control write, moves the rise of irqPending by a whole period. The bench measures that rise against an exact edge count, so it is caught at the first interrupt. Queue pointer or occupancy errors show at once on the status bits, or on the first pop as a wrong or repeated pulse value.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CYCLE = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_LEFT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_RIGHT = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ACK   = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleTick;  // period boundary: pop both queues
    logic irqEvent;    // divider reached zero
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12,
  parameter int DIV_W  = 4,
  parameter int DIV_LSB = 8,
  parameter int DMA_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output pwmStrobe_t        strobes,
  output logic              irqPending,
  output logic              dmaReq
);
  localparam int DCNT_W = DIV_W + 1;
  localparam logic [DCNT_W-1:0] DIV_MAX = DCNT_W'(1 << DIV_W);

  logic [CNT_W-1:0]  cycleReg, cycleCnt;
  logic [DIV_W-1:0]  divField;
  logic              dmaEn;
  logic [DCNT_W-1:0] divCnt;
  logic [DCNT_W-1:0] divN, newDivN;
  logic              ctrlWr, cycleWr, ackWr, tick, event_;

  assign ctrlWr  = wrEn && (wrAddr == ADR_CTRL);
  assign cycleWr = wrEn && (wrAddr == ADR_CYCLE);
  assign ackWr   = wrEn && (wrAddr == ADR_ACK);

  function automatic logic [DCNT_W-1:0] fieldToN(input logic [DIV_W-1:0] f);
    return (f == '0) ? DIV_MAX : DCNT_W'(f);
  endfunction

  assign divN    = fieldToN(divField);
  assign newDivN = fieldToN(wrData[DIV_LSB +: DIV_W]);

  assign tick   = (cycleReg != '0) && (cycleCnt == cycleReg - CNT_W'(1));
  assign event_ = tick && (divCnt == DCNT_W'(1)) && !ctrlWr;

  assign strobes.sampleTick = tick;
  assign strobes.irqEvent   = event_;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleReg <= '0;
      divField <= '0;
      dmaEn    <= 1'b0;
    end else begin
      if (cycleWr) cycleReg <= wrData[CNT_W-1:0];
      if (ctrlWr) begin
        divField <= wrData[DIV_LSB +: DIV_W];
        dmaEn    <= wrData[DMA_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  cycleCnt <= '0;
    else if (cycleWr)           cycleCnt <= '0;
    else if (cycleReg == '0)    cycleCnt <= '0;
    else if (tick)              cycleCnt <= '0;
    else                        cycleCnt <= cycleCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)       divCnt <= DIV_MAX;
    else if (ctrlWr) divCnt <= newDivN;
    else if (tick)   divCnt <= (divCnt == DCNT_W'(1)) ? divN : divCnt - DCNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPending <= 1'b0;
      dmaReq     <= 1'b0;
    end else begin
      if (event_)     irqPending <= 1'b1;
      else if (ackWr) irqPending <= 1'b0;
      dmaReq <= event_ && dmaEn;
    end
  end
endmodule

// File: rtl/pwm_timer_fifo.sv
module pwm_timer_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushVal,
  input  logic             pop,
  output logic [WIDTH-1:0] curVal,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [OCC_W-1:0] occ;
  logic doPush, doPop;

  assign full   = (occ == OCC_W'(DEPTH));
  assign empty  = (occ == '0);
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      occ    <= '0;
      curVal <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushVal;
        wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + PTR_W'(1);
      end
      if (doPop) begin
        curVal <= mem[rdPtr];
        rdPtr  <= (rdPtr == LAST) ? '0 : rdPtr + PTR_W'(1);
      end
      occ <= occ + OCC_W'(doPush) - OCC_W'(doPop);
    end
  end
endmodule

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PW_W   = 12,
  parameter int DEPTH  = 3,
  parameter int CHANS  = 2,
  parameter int FULL_BIT  = 15,
  parameter int EMPTY_BIT = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  pwmStrobe_t        strobes,
  output logic [PW_W-1:0]   pulseOut [CHANS],
  output logic [DATA_W-1:0] statusOut [CHANS]
);
  logic [PW_W-1:0] storeVal;
  assign storeVal = wrData[PW_W-1:0] - PW_W'(1);

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
    logic chPush, chFull, chEmpty;
    assign chPush = wrEn && (wrAddr == ADR_LEFT + ADDR_W'(ch));

    pwm_timer_fifo #(.WIDTH(PW_W), .DEPTH(DEPTH)) fifo_i (
      .clk     (clk),
      .rstN    (rstN),
      .push    (chPush),
      .pushVal (storeVal),
      .pop     (strobes.sampleTick),
      .curVal  (pulseOut[ch]),
      .full    (chFull),
      .empty   (chEmpty)
    );

    always_comb begin
      statusOut[ch] = '0;
      statusOut[ch][FULL_BIT]  = chFull;
      statusOut[ch][EMPTY_BIT] = chEmpty;
    end
  end
endmodule

// File: rtl/pwm_sample_timer.sv
module pwm_sample_timer
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PW_W   = 12,
  parameter int DEPTH  = 3,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [PW_W-1:0]   leftPulse,
  output logic [PW_W-1:0]   rightPulse,
  output logic [DATA_W-1:0] leftStatus,
  output logic [DATA_W-1:0] rightStatus,
  output logic              irqPending,
  output logic              dmaReq
);
  pwmStrobe_t      strobes;
  logic [PW_W-1:0]   pulseOut [2];
  logic [DATA_W-1:0] statusOut [2];

  pwm_timer_ctrl #(.DATA_W(DATA_W), .CNT_W(PW_W), .DIV_W(DIV_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .strobes    (strobes),
    .irqPending (irqPending),
    .dmaReq     (dmaReq)
  );

  pwm_timer_dp #(.DATA_W(DATA_W), .PW_W(PW_W), .DEPTH(DEPTH), .CHANS(2)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobes   (strobes),
    .pulseOut  (pulseOut),
    .statusOut (statusOut)
  );

  assign leftPulse   = pulseOut[0];
  assign rightPulse  = pulseOut[1];
  assign leftStatus  = statusOut[0];
  assign rightStatus = statusOut[1];
endmodule

// File: rtl/pwm_sample_timer_chk.sv
module pwm_sample_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [2:0]  wrAddr,
  input logic        sampleTick,
  input logic        irqEvent,
  input logic [11:0] leftPulse,
  input logic [15:0] leftStatus,
  input logic [15:0] rightStatus,
  input logic        irqPending,
  input logic        dmaReq
);
  p_event_sets_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqEvent |=> irqPending);

  p_dma_needs_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> irqPending);

  p_irq_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !(wrEn && wrAddr == 3'd4)) |=> irqPending);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 3'd4 && !irqEvent) |=> !irqPending);

  p_status_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(leftStatus[15] && leftStatus[14]) && !(rightStatus[15] && rightStatus[14]));

  p_hold_between_pops_r9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> $stable(leftPulse));
endmodule

bind pwm_sample_timer pwm_sample_timer_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .sampleTick  (strobes.sampleTick),
  .irqEvent    (strobes.irqEvent),
  .leftPulse   (leftPulse),
  .leftStatus  (leftStatus),
  .rightStatus (rightStatus),
  .irqPending  (irqPending),
  .dmaReq      (dmaReq)
);

// File: tb/pwm_sample_timer_tb_top.sv
module pwm_sample_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [11:0] leftPulse, rightPulse;
  logic [15:0] leftStatus, rightStatus;
  logic        irqPending, dmaReq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_sample_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .leftPulse(leftPulse), .rightPulse(rightPulse),
    .leftStatus(leftStatus), .rightStatus(rightStatus),
    .irqPending(irqPending), .dmaReq(dmaReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one write; returns just after the negedge following the write edge
  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    check("R7 reset left status", leftStatus, 32'h4000);
    check("R7 reset right status", rightStatus, 32'h4000);
    check("R8 reset irq", irqPending, 0);
    check("R6 reset dma", dmaReq, 0);
    check("R2 reset pulse", leftPulse, 0);
  endtask

  task automatic testQueues();
    regWrite(3'd2, 16'h0100);
    regWrite(3'd2, 16'h0000);
    regWrite(3'd2, 16'h1234);
    check("R7 left full", leftStatus, 32'h8000);
    regWrite(3'd2, 16'h0050);   // dropped (R9)
    regWrite(3'd3, 16'h0002);
    check("R7 right partial", rightStatus, 32'h0000);
    regWrite(3'd1, 16'hF002);   // period 2 (R1 masking)
    waitEdges(1);
    check("R1 no pop before period", leftPulse, 0);
    waitEdges(1);
    check("R2 first left pop", leftPulse, 12'h0FF);
    check("R2 first right pop", rightPulse, 12'h001);
    waitEdges(2);
    check("R2 zero wraps", leftPulse, 12'hFFF);
    check("R9 right holds when empty", rightPulse, 12'h001);
    check("R7 right empty", rightStatus, 32'h4000);
    waitEdges(2);
    check("R2 masked to 12 bits", leftPulse, 12'h233);
    waitEdges(2);
    check("R9 full write dropped, value held", leftPulse, 12'h233);
    check("R7 left empty", leftStatus, 32'h4000);
  endtask

  task automatic testStopped();
    regWrite(3'd1, 16'h0000);
    regWrite(3'd4, 16'h0000);
    regWrite(3'd2, 16'h0011);
    waitEdges(40);
    check("R4 no pop while stopped", leftPulse, 12'h233);
    check("R4 entry kept", leftStatus, 32'h0000);
    check("R4 no irq while stopped", irqPending, 0);
  endtask

  task automatic testDivider();
    regWrite(3'd0, 16'h0380);   // N=3, refill request on
    regWrite(3'd1, 16'h0004);
    waitEdges(11);
    check("R3 no irq before N periods", irqPending, 0);
    waitEdges(1);
    check("R3 irq after N periods", irqPending, 1);
    check("R6 dma pulse", dmaReq, 1);
    waitEdges(1);
    check("R6 dma one cycle", dmaReq, 0);
    waitEdges(20);
    check("R8 irq held without ack", irqPending, 1);
    regWrite(3'd4, 16'h0000);
    check("R8 ack clears irq", irqPending, 0);
    regWrite(3'd1, 16'h0000);
    regWrite(3'd4, 16'h0000);
  endtask

  task automatic testSixteen();
    regWrite(3'd0, 16'h0000);   // field 0 -> 16, request off
    regWrite(3'd1, 16'h0002);
    waitEdges(31);
    check("R3 field 0 not yet", irqPending, 0);
    waitEdges(1);
    check("R3 field 0 means 16", irqPending, 1);
    check("R6 no dma when disabled", dmaReq, 0);
    regWrite(3'd1, 16'h0000);
    regWrite(3'd4, 16'h0000);
  endtask

  task automatic testReload();
    regWrite(3'd0, 16'h0400);   // N=4
    regWrite(3'd1, 16'h0003);
    waitEdges(6);               // two periods done
    regWrite(3'd0, 16'h0400);   // reload
    waitEdges(10);
    check("R5 reload delays irq", irqPending, 0);
    waitEdges(1);
    check("R5 irq after full N", irqPending, 1);
    regWrite(3'd1, 16'h0000);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);
    testReset();
    testQueues();
    testStopped();
    testDivider();
    testSixteen();
    testReload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule